// File: doc/BRIEF.md
# Addressed Serial Command Front-End for a Quad Trim Channel Device

This block is the serial slave port of a trim device with four channels. Channels 0 and 1 are potentiometer channels. Channels 2 and 3 are comparator channels. While chip select is low, a host shifts in bytes. The first byte of a frame identifies the device. It carries a fixed type code, a reserved field and a two-bit address, and the address must match two strap pins. The second byte carries a command, a data-register index and a channel index. A third byte, when the command needs one, carries write data from the host or read data back to the host.

Every channel owns one 8-bit control register and four 8-bit data registers, all held in plain flops. The control register of a pot channel drives that pot's wiper position. The control register of a comparator channel drives that comparator's power, output-enable and latch controls. Commands read or write either kind of register, or copy between a data register and the control register of the same channel. A frame that fails identification is ignored until chip select rises again.

Top module: `trim_cmd_port`

## Requirements
- R1: Bits are taken most significant bit first on each rising edge of `sck` while `cs_n` is low. Raising `cs_n` discards any partial byte, so the next frame starts with a fresh byte.
- R2: The first byte is accepted only when bits 7:4 equal 4'b0101, bits 3:2 equal 2'b00 and bits 1:0 equal `addr_pins`. On any mismatch, no register changes for the rest of the frame.
- R3: When `cs_n` is high the block waits for a new identification byte, and `sdo_oe` is 0.
- R4: The second byte splits into an opcode (bits 7:4), a data-register index (bits 3:2) and a channel index (bits 1:0). Channels 0 and 1 are pots and channels 2 and 3 are comparators.
- R5: Opcode 4'b1010 writes the third byte into the selected control register, with bits 7:6 forced to 0. Each pot's `wiper` output shows bits 5:0 of its control register. For comparator channel c (output index c-2), `cmp_pwr` shows bit 0, `cmp_oe` shows bit 1 and `cmp_latch` shows bit 2.
- R6: Opcode 4'b1001 returns the selected control register during the third byte, most significant bit first, with `sdo_oe` high. The first bit is valid before the first rising edge of that byte, and later bits change on falling edges of `sck`.
- R7: Opcode 4'b1100 writes the third byte, all 8 bits, into data register R of the selected channel. Opcode 4'b1011 returns that register in the same way as R6.
- R8: Opcode 4'b1101 copies data register R into the control register with bits 7:6 forced to 0. Opcode 4'b1110 copies the control register into data register R. Both take effect at the end of the second byte.
- R9: Every other opcode leaves all registers unchanged.
- R10: Bytes after the one that completes a command are ignored until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| addr_pins | input | 2 | Strap address compared with identification bits 1:0 |
| cs_n | input | 1 | Active-low chip select, frames a command |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data; meaningful while sdo_oe is high |
| sdo_oe | output | 1 | Drive enable for the sdo pad buffer |
| wiper | output | 2x6 | Wiper positions of pot channels 0 and 1 |
| cmp_pwr | output | 2 | Comparator power bits, channels 2 and 3 |
| cmp_oe | output | 2 | Comparator output-enable bits, channels 2 and 3 |
| cmp_latch | output | 2 | Comparator latch bits, channels 2 and 3 |

## Verification
Writes of 8'hFF to control registers of both formats show that bits 7:6 are forced to 0. Distinct patterns written to different data registers show that the channel and register fields are decoded separately, because a swapped index returns a wrong byte. Rejected frames each differ from a good header in one field: type code, reserved bits, or the address with the pins moved. Each rejected frame carries a write that would be visible, so a relaxed compare of any field shows up as a changed output or a changed read-back. Copy commands, unknown opcodes, trailing bytes and a frame cut off mid-byte check the ordering rules, while a per-clock model of the exposed control bits compares the outputs between frames.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int NCH      = 4;
    localparam int NPOT     = 2;
    localparam int NCMP     = NCH - NPOT;
    localparam int NREG     = 4;
    localparam int W        = 8;
    localparam int WIPER_W  = 6;
    localparam int CH_W     = $clog2(NCH);
    localparam int REG_W    = $clog2(NREG);
    localparam int BIT_W    = $clog2(W);
    localparam logic [3:0] TYPE_CODE = 4'b0101;
    localparam logic [W-1:0] POT_MASK = 8'h3F;
    localparam logic [W-1:0] CMP_MASK = 8'h3F;

    localparam logic [3:0] OP_RD_CTRL = 4'b1001;
    localparam logic [3:0] OP_WR_CTRL = 4'b1010;
    localparam logic [3:0] OP_RD_DATA = 4'b1011;
    localparam logic [3:0] OP_WR_DATA = 4'b1100;
    localparam logic [3:0] OP_D2C     = 4'b1101;
    localparam logic [3:0] OP_C2D     = 4'b1110;

    typedef enum logic [2:0] {
        PH_ID, PH_CMD, PH_WDATA, PH_RDATA, PH_SKIP
    } phase_t;

    typedef struct packed {
        logic [3:0]       op;
        logic [REG_W-1:0] ridx;
        logic [CH_W-1:0]  ch;
    } cmd_t;

    typedef struct packed {
        logic             en;
        logic             to_ctrl;
        logic [CH_W-1:0]  ch;
        logic [REG_W-1:0] ridx;
        logic [W-1:0]     d;
    } wr_req_t;

    function automatic logic id_match(input logic [W-1:0] b, input logic [1:0] pins);
        return (b[7:4] == TYPE_CODE) && (b[3:2] == 2'b00) && (b[1:0] == pins);
    endfunction

    function automatic logic [W-1:0] ctrl_mask(input logic [CH_W-1:0] ch);
        return (int'(ch) < NPOT) ? POT_MASK : CMP_MASK;
    endfunction
endpackage

// File: rtl/trim_spi_link.sv
module trim_spi_link
    import trim_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         sck,
    input  logic         mosi,
    output logic         byte_vld,
    output logic [W-1:0] byte_data,
    output logic         sck_fall
);
    logic             sck_q;
    logic [BIT_W-1:0] bit_cnt;
    logic [W-2:0]     shreg;
    logic             sck_rise;

    assign sck_rise = !cs_n && sck && !sck_q;
    assign sck_fall = !cs_n && !sck && sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            sck_q    <= sck;
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[W-3:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(W-1)) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {shreg, mosi};
                end
            end
        end
    end

    assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (bit_cnt == '0));
    assert_vld_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile
    import trim_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  wr_req_t                           wr,
    input  logic [CH_W-1:0]                   rd_ch,
    input  logic [REG_W-1:0]                  rd_idx,
    output logic [W-1:0]                      rd_ctrl,
    output logic [W-1:0]                      rd_data,
    output logic [NCH-1:0][W-1:0]             ctrl_q
);
    logic [NCH-1:0][NREG-1:0][W-1:0] data_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[c] <= '0;
                data_q[c] <= '0;
            end else if (wr.en && wr.ch == CH_W'(c)) begin
                if (wr.to_ctrl)
                    ctrl_q[c] <= wr.d & ctrl_mask(CH_W'(c));
                else
                    data_q[c][wr.ridx] <= wr.d;
            end
        end

        assert_ctrl_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[c][7:6] == 2'b00);
    end

    assign rd_ctrl = ctrl_q[rd_ch];
    assign rd_data = data_q[rd_ch][rd_idx];

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> ($stable(ctrl_q) && $stable(data_q)));
endmodule

// File: rtl/trim_cmd_port.sv
module trim_cmd_port
    import trim_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                addr_pins,
    input  logic                      cs_n,
    input  logic                      sck,
    input  logic                      mosi,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic [NPOT-1:0][WIPER_W-1:0] wiper,
    output logic [NCMP-1:0]           cmp_pwr,
    output logic [NCMP-1:0]           cmp_oe,
    output logic [NCMP-1:0]           cmp_latch
);
    logic                 byte_vld;
    logic [W-1:0]         byte_data;
    logic                 sck_fall;
    phase_t               phase;
    cmd_t                 cur, held;
    wr_req_t              wr;
    logic [W-1:0]         rd_ctrl, rd_data, tx;
    logic                 primed;
    logic [NCH-1:0][W-1:0] ctrl_q;

    trim_spi_link u_link (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .byte_vld(byte_vld), .byte_data(byte_data), .sck_fall(sck_fall)
    );

    assign cur = cmd_t'(byte_data);

    trim_regfile u_regs (
        .clk(clk), .rst(rst), .wr(wr),
        .rd_ch(cur.ch), .rd_idx(cur.ridx),
        .rd_ctrl(rd_ctrl), .rd_data(rd_data), .ctrl_q(ctrl_q)
    );

    always_comb begin
        wr = '0;
        if (byte_vld && !cs_n) begin
            if (phase == PH_CMD && cur.op == OP_D2C)
                wr = '{en: 1'b1, to_ctrl: 1'b1, ch: cur.ch, ridx: cur.ridx, d: rd_data};
            else if (phase == PH_CMD && cur.op == OP_C2D)
                wr = '{en: 1'b1, to_ctrl: 1'b0, ch: cur.ch, ridx: cur.ridx, d: rd_ctrl};
            else if (phase == PH_WDATA)
                wr = '{en: 1'b1, to_ctrl: (held.op == OP_WR_CTRL), ch: held.ch,
                       ridx: held.ridx, d: byte_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            phase  <= PH_ID;
            held   <= '0;
            tx     <= '0;
            primed <= 1'b0;
        end else begin
            if (byte_vld) begin
                unique case (phase)
                    PH_ID:  phase <= id_match(byte_data, addr_pins) ? PH_CMD : PH_SKIP;
                    PH_CMD: begin
                        held <= cur;
                        unique case (cur.op)
                            OP_RD_CTRL: begin phase <= PH_RDATA; tx <= rd_ctrl; primed <= 1'b1; end
                            OP_RD_DATA: begin phase <= PH_RDATA; tx <= rd_data; primed <= 1'b1; end
                            OP_WR_CTRL, OP_WR_DATA: phase <= PH_WDATA;
                            default: phase <= PH_SKIP;
                        endcase
                    end
                    default: phase <= PH_SKIP;
                endcase
            end else if (sck_fall && phase == PH_RDATA) begin
                if (primed) primed <= 1'b0;
                else        tx     <= {tx[W-2:0], 1'b0};
            end
        end
    end

    assign sdo    = tx[W-1];
    assign sdo_oe = !cs_n && (phase == PH_RDATA);

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        assign wiper[p] = ctrl_q[p][WIPER_W-1:0];
    end
    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
        assign cmp_pwr[c]   = ctrl_q[NPOT+c][0];
        assign cmp_oe[c]    = ctrl_q[NPOT+c][1];
        assign cmp_latch[c] = ctrl_q[NPOT+c][2];
    end

    assert_idle_after_cs_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (phase == PH_ID));
    assert_reject_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !wr.en);
    assert_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RDATA && !sck_fall && !byte_vld && !cs_n) |=> $stable(sdo));
    assert_single_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !cs_n) |=> (phase == PH_SKIP));
endmodule

// File: tb/sim_trim_cmd_port.sv
module sim_trim_cmd_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] addr_pins = 2'b01;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic sdo, sdo_oe;
    logic [1:0][5:0] wiper;
    logic [1:0] cmp_pwr, cmp_oe, cmp_latch;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    logic [7:0] ref_ctrl [4];
    logic [7:0] ref_data [4][4];

    always #5 clk = ~clk;

    trim_cmd_port u0 (
        .clk(clk), .rst(rst), .addr_pins(addr_pins), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .sdo(sdo), .sdo_oe(sdo_oe), .wiper(wiper),
        .cmp_pwr(cmp_pwr), .cmp_oe(cmp_oe), .cmp_latch(cmp_latch)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R5 / R3: compare exposed control bits and the drive enable every idle clock
    always @(negedge clk) begin
        if (mon_en) begin
            for (int p = 0; p < 2; p++)
                check("R5 wiper", {2'b00, wiper[p]}, {2'b00, ref_ctrl[p][5:0]});
            for (int c = 0; c < 2; c++)
                check("R5 cmp bits", {5'd0, cmp_latch[c], cmp_oe[c], cmp_pwr[c]},
                      {5'd0, ref_ctrl[2+c][2:0]});
            check("R3 sdo_oe idle", {7'd0, sdo_oe}, 8'h00);
        end
    end

    task automatic xfer(input logic [7:0] tb, output logic [7:0] rb, output bit oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); mosi = tb[i];
            repeat (3) @(negedge clk);
            rb[i] = sdo;
            if (!sdo_oe) oe_all = 1'b0;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    function automatic bit id_good(input logic [7:0] b);
        return b[7:4] == 4'b0101 && b[3:2] == 2'b00 && b[1:0] == addr_pins;
    endfunction

    // sends n bytes; model updated from the requirements; read byte returned
    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, input int n, output logic [7:0] rd);
        logic [7:0] bytes [4];
        logic [7:0] rb;
        bit oe;
        logic [3:0] op;
        logic [1:0] ch, ri;
        bytes = '{b0, b1, b2, b3};
        rd = 8'h00;
        mon_en = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            xfer(bytes[k], rb, oe);
            if (k == 2) begin
                rd = rb;
                if (n >= 2 && id_good(b0) && (b1[7:4] == 4'b1001 || b1[7:4] == 4'b1011))
                    check("R6 sdo_oe during read", {7'd0, oe}, 8'h01);
            end
        end
        repeat (2) @(negedge clk); cs_n = 1'b1;
        op = b1[7:4]; ri = b1[3:2]; ch = b1[1:0];
        if (n >= 2 && id_good(b0)) begin
            case (op)
                4'b1010: if (n >= 3) ref_ctrl[ch] = b2 & 8'h3F;
                4'b1100: if (n >= 3) ref_data[ch][ri] = b2;
                4'b1101: ref_ctrl[ch] = ref_data[ch][ri] & 8'h3F;
                4'b1110: ref_data[ch][ri] = ref_ctrl[ch];
                default: ;
            endcase
        end
        repeat (3) @(negedge clk);
        mon_en = 1'b1;
    endtask

    task automatic rd_ctrl(input int ch, input string req);
        logic [7:0] r;
        frame({6'b010100, addr_pins}, {4'b1001, 2'b00, 2'(ch)}, 8'h00, 8'h00, 3, r);
        check(req, r, ref_ctrl[ch]);
    endtask

    task automatic rd_data(input int ch, input int ri, input string req);
        logic [7:0] r;
        frame({6'b010100, addr_pins}, {4'b1011, 2'(ri), 2'(ch)}, 8'h00, 8'h00, 3, r);
        check(req, r, ref_data[ch][ri]);
    endtask

    task automatic wr(input logic [3:0] op, input int ch, input int ri, input logic [7:0] d);
        logic [7:0] r;
        frame({6'b010100, addr_pins}, {op, 2'(ri), 2'(ch)}, d, 8'h00, 3, r);
    endtask

    initial begin
        logic [7:0] r;
        for (int c = 0; c < 4; c++) begin
            ref_ctrl[c] = 8'h00;
            for (int i = 0; i < 4; i++) ref_data[c][i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // reset state
        check("R3 reset sdo_oe", {7'd0, sdo_oe}, 8'h00);
        check("R5 reset wiper0", {2'b00, wiper[0]}, 8'h00);
        check("R5 reset cmp", {2'b00, cmp_latch, cmp_oe, cmp_pwr}, 8'h00);
        mon_en = 1'b1;

        // R5 control writes on both formats, masking bits 7:6
        wr(4'b1010, 0, 0, 8'hFF);
        rd_ctrl(0, "R5 pot0 ctrl masked");
        wr(4'b1010, 1, 0, 8'h9A);
        rd_ctrl(1, "R6 pot1 ctrl readback");
        wr(4'b1010, 2, 0, 8'hFF);
        rd_ctrl(2, "R5 cmp2 ctrl masked");
        wr(4'b1010, 3, 0, 8'h05);
        rd_ctrl(3, "R4 cmp3 channel select");

        // R7 data registers, distinct patterns per channel/index
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                wr(4'b1100, c, i, 8'(8'h11 * (c * 4 + i) + 8'h80));
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                rd_data(c, i, "R7 data readback");

        // R8 copies
        frame({6'b010100, addr_pins}, {4'b1101, 2'd2, 2'd1}, 8'h00, 8'h00, 2, r);
        rd_ctrl(1, "R8 data->ctrl masked");
        frame({6'b010100, addr_pins}, {4'b1110, 2'd3, 2'd2}, 8'h00, 8'h00, 2, r);
        rd_data(2, 3, "R8 ctrl->data");

        // R2 rejected headers, each carrying a visible write
        frame(8'b0110_0001, {4'b1010, 4'b0000}, 8'h2A, 8'h00, 3, r);
        rd_ctrl(0, "R2 bad type code ignored");
        frame(8'b0101_0100 | {6'd0, addr_pins}, {4'b1010, 4'b0000}, 8'h2A, 8'h00, 3, r);
        rd_ctrl(0, "R2 reserved bits ignored");
        frame(8'b0101_0010, {4'b1100, 4'b0001}, 8'h3C, 8'h00, 3, r);
        rd_data(1, 0, "R2 wrong address ignored");
        addr_pins = 2'b10;
        frame(8'b0101_0001, {4'b1010, 4'b0011}, 8'h07, 8'h00, 3, r);
        rd_ctrl(3, "R2 old address after pin change");
        wr(4'b1010, 3, 0, 8'h06);
        rd_ctrl(3, "R2 new address accepted");

        // R9 unknown opcodes
        frame({6'b010100, addr_pins}, {4'b0000, 4'b0000}, 8'h15, 8'h00, 3, r);
        frame({6'b010100, addr_pins}, {4'b1111, 4'b0110}, 8'h15, 8'h00, 3, r);
        rd_ctrl(0, "R9 unknown opcode ctrl");
        rd_data(2, 1, "R9 unknown opcode data");

        // R10 trailing byte after write ignored
        frame({6'b010100, addr_pins}, {4'b1100, 2'd0, 2'd3}, 8'hA5, 8'h5A, 4, r);
        rd_data(3, 0, "R10 trailing byte ignored");
        frame({6'b010100, addr_pins}, {4'b1010, 2'd0, 2'd0}, 8'h12, 8'h34, 4, r);
        rd_ctrl(0, "R10 trailing ctrl byte ignored");

        // R1 frame cut mid-byte, then a clean frame
        mon_en = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); mosi = 1'b1;
            repeat (3) @(negedge clk); sck = 1'b1;
            repeat (4) @(negedge clk); sck = 1'b0;
        end
        repeat (2) @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(4'b1010, 1, 0, 8'h21);
        rd_ctrl(1, "R1 recovery after partial byte");

        mon_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule